// File: doc/BRIEF.md
# Multi-Phase Reset Release Sequencer

This block decides when a chip leaves reset. It runs on a free-running internal oscillator clock and steps through five phases. Phase 0 waits for the clock and the supply. Phase 1 is the long hold after an external or functional reset. Phases 2 and 3 cover flash initialization. The idle phase releases the system. Each phase has a minimum dwell, counted in clock edges from entry to the phase or from the last event that sends the sequencer to it. The phase can also leave only when its handshake inputs are satisfied.

Reset events come in three classes, and each class re-enters the sequence at a different place. Power-on and enabled destructive events restart from phase 0 from any phase. An unmasked external reset, or an enabled functional event that is not marked short, restarts from phase 1. An enabled short functional event, accepted only in idle, enters phase 3 directly. Event enables, the external mask and the per-source short configuration are plain input vectors.

Top module: `rst_phase_seq`

## Requirements
- R1: While `por_n_i` is low, `phase_o` is 0 (phase codes: 0 = phase 0, 1 = phase 1, 2 = phase 2, 3 = phase 3, 4 = idle), `sys_rst_hold_o` is 1 and `flash_req_o` is 0.
- R2: A destructive event bit that is high while its enable bit is high moves the sequencer to phase 0 on that clock edge, from any phase. It takes priority over external and functional events in the same cycle. Event bits whose enable is low have no effect.
- R3: Phase 0 moves to phase 1 only while `osc_ok_i` and `vreg_ok_i` are both high. With both high, the first phase change after power-on release happens on the 4th rising edge, and a phase 0 entered on edge E is left on edge E+4.
- R4: An external event with `ext_en_i` high, or an enabled functional event whose short bit is 0, moves the sequencer to phase 1 on that edge from phase 1, 2, 3 or idle. In phase 1 it restarts the dwell. Such events are ignored in phase 0, and they are also ignored when masked or disabled.
- R5: Phase 1 is left for phase 2 on edge E+351, where E is the edge of entry or of the last long-class event.
- R6: Phase 2 moves to phase 3 only while `flash_done_i` is high, and no earlier than edge E+9 after entry on edge E.
- R7: An enabled functional event whose short bit is 1 moves the sequencer from idle to phase 3 on that edge. In every other phase it is ignored and does not restart any dwell.
- R8: Phase 3 moves to idle only while `flash_done_i` is high, and no earlier than edge E+41 after entry on edge E. Idle is entered only from phase 3.
- R9: `sys_rst_hold_o` is high in every phase except idle. `flash_req_o` is high in phases 2 and 3 only.
- R10: The dwell counter saturates at the current phase's minimum and never exceeds the largest minimum (350).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running internal oscillator clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| dstr_evt_i | input | N_DSTR | Destructive reset event per source |
| dstr_en_i | input | N_DSTR | Enable per destructive source |
| ext_evt_i | input | 1 | External reset event |
| ext_en_i | input | 1 | External reset unmask |
| func_evt_i | input | N_FUNC | Functional reset event per source |
| func_en_i | input | N_FUNC | Enable per functional source |
| func_short_i | input | N_FUNC | Per-source short-sequence selection |
| osc_ok_i | input | 1 | Internal oscillator stable |
| vreg_ok_i | input | 1 | Regulator output good |
| flash_done_i | input | 1 | Flash initialization complete |
| phase_o | output | 3 | Current phase code |
| sys_rst_hold_o | output | 1 | System held in reset |
| flash_req_o | output | 1 | Flash initialization request |

## Verification
The assertions watch each cycle for event routing: destructive events land in phase 0, and long-class events land in phase 1 outside phase 0. They also check that short events from idle land in phase 3. Further cycle-by-cycle checks hold phase 0 while the supply or clock is not good and hold phase 2 without flash completion. They confirm that phase 2 is only reached from phase 1 and that reset hold only drops out of phase 3. The counter bound is checked as well. The exact dwell lengths need the bench's scenarios with their measured phase durations. So do the dwell restart on a repeated phase-1 event and the silence of ignored, masked or disabled events.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    PH_ZERO  = 3'd0,
    PH_ONE   = 3'd1,
    PH_TWO   = 3'd2,
    PH_THREE = 3'd3,
    PH_IDLE  = 3'd4
  } phase_e;

  // minimum dwell (in edges past entry) required by each phase
  function automatic int dwell_need(phase_e ph, int m0, int m1, int m2, int m3);
    case (ph)
      PH_ZERO:  return m0;
      PH_ONE:   return m1;
      PH_TWO:   return m2;
      PH_THREE: return m3;
      default:  return 0;
    endcase
  endfunction

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic phase_e next_in_order(phase_e ph);
    case (ph)
      PH_ZERO:  return PH_ONE;
      PH_ONE:   return PH_TWO;
      PH_TWO:   return PH_THREE;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rps_evt_qualify.sv
module rps_evt_qualify #(
  parameter int N_DSTR = 2,
  parameter int N_FUNC = 3
) (
  input  logic [N_DSTR-1:0] dstr_evt,
  input  logic [N_DSTR-1:0] dstr_en,
  input  logic              ext_evt,
  input  logic              ext_en,
  input  logic [N_FUNC-1:0] func_evt,
  input  logic [N_FUNC-1:0] func_en,
  input  logic [N_FUNC-1:0] func_short,
  output logic              dstr_hit,
  output logic              long_hit,
  output logic              short_hit
);

  logic [N_DSTR-1:0] dstr_live;
  logic [N_FUNC-1:0] func_long;
  logic [N_FUNC-1:0] func_shrt;

  for (genvar d = 0; d < N_DSTR; d++) begin : g_dstr
    assign dstr_live[d] = dstr_evt[d] & dstr_en[d];
  end

  for (genvar f = 0; f < N_FUNC; f++) begin : g_func
    logic live;
    assign live         = func_evt[f] & func_en[f];
    assign func_long[f] = live & ~func_short[f];
    assign func_shrt[f] = live &  func_short[f];
  end

  assign dstr_hit  = |dstr_live;
  assign long_hit  = (ext_evt & ext_en) | (|func_long);
  assign short_hit = |func_shrt;

endmodule

// File: rtl/rps_dwell_cnt.sv
module rps_dwell_cnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          met
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (cnt < limit)   cnt <= cnt + 1'b1;
  end

  assign met = (cnt >= limit);

endmodule

// File: rtl/rps_phase_ctrl.sv
module rps_phase_ctrl
  import rps_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   dstr_hit,
  input  logic   long_hit,
  input  logic   short_hit,
  input  logic   osc_ok,
  input  logic   vreg_ok,
  input  logic   flash_done,
  input  logic   dwell_met,
  output phase_e phase,
  output logic   restart
);

  phase_e ph_n;
  logic   ready;

  // handshake plus dwell condition for leaving the current phase
  always_comb begin
    case (phase)
      PH_ZERO:           ready = dwell_met & osc_ok & vreg_ok;
      PH_ONE:            ready = dwell_met;
      PH_TWO, PH_THREE:  ready = dwell_met & flash_done;
      default:           ready = 1'b0;
    endcase
  end

  always_comb begin
    ph_n    = phase;
    restart = 1'b0;
    if (dstr_hit) begin
      ph_n    = PH_ZERO;
      restart = 1'b1;
    end else if (long_hit && phase != PH_ZERO) begin
      ph_n    = PH_ONE;
      restart = 1'b1;
    end else if (short_hit && phase == PH_IDLE) begin
      ph_n    = PH_THREE;
      restart = 1'b1;
    end else if (ready) begin
      ph_n    = next_in_order(phase);
      restart = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_ZERO;
    else        phase <= ph_n;
  end

endmodule

// File: rtl/rst_phase_seq.sv
module rst_phase_seq
  import rps_pkg::*;
#(
  parameter int N_DSTR  = 2,
  parameter int N_FUNC  = 3,
  parameter int P0_MIN  = 3,
  parameter int P1_MIN  = 350,
  parameter int P2_MIN  = 8,
  parameter int P3_MIN  = 40
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic [N_DSTR-1:0] dstr_evt_i,
  input  logic [N_DSTR-1:0] dstr_en_i,
  input  logic              ext_evt_i,
  input  logic              ext_en_i,
  input  logic [N_FUNC-1:0] func_evt_i,
  input  logic [N_FUNC-1:0] func_en_i,
  input  logic [N_FUNC-1:0] func_short_i,
  input  logic              osc_ok_i,
  input  logic              vreg_ok_i,
  input  logic              flash_done_i,
  output logic [2:0]        phase_o,
  output logic              sys_rst_hold_o,
  output logic              flash_req_o
);

  localparam int CNT_MAX = max_of4(P0_MIN, P1_MIN, P2_MIN, P3_MIN);
  localparam int CW      = $clog2(CNT_MAX + 1);

  // named internal events, visible to the bound checker
  logic          dstr_hit;
  logic          long_hit;
  logic          short_hit;
  logic          restart;
  logic          dwell_met;
  logic [CW-1:0] dwell_cnt;
  logic [CW-1:0] dwell_lim;
  phase_e        phase;

  rps_evt_qualify #(.N_DSTR(N_DSTR), .N_FUNC(N_FUNC)) u_qual (
    .dstr_evt   (dstr_evt_i),
    .dstr_en    (dstr_en_i),
    .ext_evt    (ext_evt_i),
    .ext_en     (ext_en_i),
    .func_evt   (func_evt_i),
    .func_en    (func_en_i),
    .func_short (func_short_i),
    .dstr_hit   (dstr_hit),
    .long_hit   (long_hit),
    .short_hit  (short_hit)
  );

  assign dwell_lim = CW'(dwell_need(phase, P0_MIN, P1_MIN, P2_MIN, P3_MIN));

  rps_dwell_cnt #(.CW(CW)) u_cnt (
    .clk   (clk_i),
    .rst_n (por_n_i),
    .clr   (restart),
    .limit (dwell_lim),
    .cnt   (dwell_cnt),
    .met   (dwell_met)
  );

  rps_phase_ctrl u_ctrl (
    .clk        (clk_i),
    .rst_n      (por_n_i),
    .dstr_hit   (dstr_hit),
    .long_hit   (long_hit),
    .short_hit  (short_hit),
    .osc_ok     (osc_ok_i),
    .vreg_ok    (vreg_ok_i),
    .flash_done (flash_done_i),
    .dwell_met  (dwell_met),
    .phase      (phase),
    .restart    (restart)
  );

  assign phase_o        = phase;
  assign sys_rst_hold_o = (phase != PH_IDLE);
  assign flash_req_o    = (phase == PH_TWO) || (phase == PH_THREE);

endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int CW      = 9,
  parameter int CNT_MAX = 350
) (
  input logic          clk_i,
  input logic          por_n_i,
  input logic [2:0]    phase_o,
  input logic          sys_rst_hold_o,
  input logic          flash_req_o,
  input logic [CW-1:0] dwell_cnt,
  input logic          dstr_hit,
  input logic          long_hit,
  input logic          short_hit,
  input logic          osc_ok_i,
  input logic          vreg_ok_i,
  input logic          flash_done_i
);

  AST_DSTR_TO_ZERO: assert property (@(posedge clk_i) disable iff (!por_n_i)
    dstr_hit |=> phase_o == 3'd0); // R2

  AST_LONG_TO_ONE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (long_hit && !dstr_hit && phase_o != 3'd0) |=> phase_o == 3'd1); // R4

  AST_SHORT_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (short_hit && !dstr_hit && !long_hit && phase_o == 3'd4) |=> phase_o == 3'd3); // R7

  AST_ZERO_WAITS_SUPPLY: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (phase_o == 3'd0 && !(osc_ok_i && vreg_ok_i)) |=> phase_o == 3'd0); // R3

  AST_TWO_WAITS_FLASH: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (phase_o == 3'd2 && !flash_done_i && !dstr_hit && !long_hit) |=> phase_o == 3'd2); // R6

  AST_TWO_FROM_ONE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (phase_o == 3'd2 && $past(phase_o) != 3'd2) |-> $past(phase_o) == 3'd1); // R5

  AST_RELEASE_FROM_THREE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(sys_rst_hold_o) |-> $past(phase_o) == 3'd3); // R8

  AST_FLASH_REQ_ENTRY: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(flash_req_o) |-> ($past(phase_o) == 3'd1 || $past(phase_o) == 3'd4)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!por_n_i)
    int'(dwell_cnt) <= CNT_MAX); // R10

endmodule

bind rst_phase_seq rps_checker #(.CW(CW), .CNT_MAX(CNT_MAX)) u_chk (
  .clk_i          (clk_i),
  .por_n_i        (por_n_i),
  .phase_o        (phase_o),
  .sys_rst_hold_o (sys_rst_hold_o),
  .flash_req_o    (flash_req_o),
  .dwell_cnt      (dwell_cnt),
  .dstr_hit       (dstr_hit),
  .long_hit       (long_hit),
  .short_hit      (short_hit),
  .osc_ok_i       (osc_ok_i),
  .vreg_ok_i      (vreg_ok_i),
  .flash_done_i   (flash_done_i)
);

// File: tb/sim_rst_phase_seq.sv
`timescale 1ns/1ps
module sim_rst_phase_seq;

  localparam int ND = 2;
  localparam int NF = 3;

  logic          clk_i = 1'b0;
  logic          por_n_i;
  logic [ND-1:0] dstr_evt_i, dstr_en_i;
  logic          ext_evt_i, ext_en_i;
  logic [NF-1:0] func_evt_i, func_en_i, func_short_i;
  logic          osc_ok_i, vreg_ok_i, flash_done_i;
  logic [2:0]    phase_o;
  logic          sys_rst_hold_o, flash_req_o;

  always #2.5 clk_i = ~clk_i;

  rst_phase_seq #(.N_DSTR(ND), .N_FUNC(NF)) u0 (.*);

  typedef struct {
    int    ph;
    int    dwell;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  task automatic check_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(int ph, int dwell, string tag);
    exp_t e;
    e.ph = ph; e.dwell = dwell; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: on each phase change, pop one expected item
  initial begin
    int   last;
    int   cnt;
    exp_t e;
    @(posedge por_n_i);
    last = phase_o;
    cnt  = 0;
    forever begin
      @(negedge clk_i);
      if (int'(phase_o) != last) begin
        if (sb.size() == 0) begin
          check_eq("unexpected phase change", int'(phase_o), last);
        end else begin
          e = sb.pop_front();
          check_eq({e.tag, " phase"}, int'(phase_o), e.ph);
          if (e.dwell >= 0) check_eq({e.tag, " dwell of prior phase"}, cnt, e.dwell);
          check_eq("R9 hold", int'(sys_rst_hold_o), int'(phase_o != 3'd4));
          check_eq("R9 flash req", int'(flash_req_o),
                   int'(phase_o == 3'd2 || phase_o == 3'd3));
        end
        cnt  = 1;
        last = phase_o;
      end else begin
        cnt++;
      end
    end
  end

  task automatic wait_phase(int ph);
    while (int'(phase_o) != ph) @(negedge clk_i);
  endtask

  task automatic pulse_dstr(int i);
    dstr_evt_i[i] = 1'b1;
    @(negedge clk_i);
    dstr_evt_i = '0;
  endtask

  task automatic pulse_ext();
    ext_evt_i = 1'b1;
    @(negedge clk_i);
    ext_evt_i = 1'b0;
  endtask

  task automatic pulse_func(int i);
    func_evt_i[i] = 1'b1;
    @(negedge clk_i);
    func_evt_i = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    por_n_i      = 1'b0;
    dstr_evt_i   = '0;
    dstr_en_i    = 2'b01;     // source 1 disabled
    ext_evt_i    = 1'b0;
    ext_en_i     = 1'b1;
    func_evt_i   = '0;
    func_en_i    = 3'b011;    // source 2 disabled
    func_short_i = 3'b010;    // source 1 short, source 0 long
    osc_ok_i     = 1'b1;
    vreg_ok_i    = 1'b1;
    flash_done_i = 1'b1;

    repeat (3) @(negedge clk_i);
    check_eq("R1 phase in reset", int'(phase_o), 0);
    check_eq("R1 hold in reset", int'(sys_rst_hold_o), 1);
    check_eq("R1 flash req in reset", int'(flash_req_o), 0);

    // full power-up sequence
    push(1, 3,  "R3 exit zero after release");
    push(2, 351, "R5 phase one dwell");
    push(3, 9,  "R6 phase two dwell");
    push(4, 41, "R8 phase three dwell");
    por_n_i = 1'b1;
    wait_phase(4);

    // disabled destructive, masked external, disabled functional: no effect
    pulse_dstr(1);
    ext_en_i = 1'b0;
    pulse_ext();
    ext_en_i = 1'b1;
    pulse_func(2);
    repeat (4) @(negedge clk_i);
    check_eq("R2/R4 masked or disabled events ignored", int'(phase_o), 4);

    // short functional from idle; second short in phase three ignored
    push(3, -1, "R7 short enters phase three");
    push(4, 41, "R7 short in phase three did not restart dwell");
    pulse_func(1);
    wait_phase(3);
    repeat (10) @(negedge clk_i);
    pulse_func(1);
    wait_phase(4);

    // external from idle, repeated in phase one restarts dwell
    push(1, -1, "R4 external enters phase one");
    push(2, 452, "R4/R10 restarted phase one dwell");
    push(3, 9,  "R6 phase two dwell");
    push(4, 41, "R8 phase three dwell");
    pulse_ext();
    wait_phase(1);
    repeat (100) @(negedge clk_i);
    pulse_ext();
    wait_phase(4);

    // long functional, then destructive plus functional together; supply gating
    push(1, -1, "R4 long functional enters phase one");
    push(0, -1, "R2 destructive wins over functional");
    pulse_func(0);
    wait_phase(1);
    repeat (20) @(negedge clk_i);
    vreg_ok_i = 1'b0;
    dstr_evt_i[0] = 1'b1;
    func_evt_i[0] = 1'b1;
    @(negedge clk_i);
    dstr_evt_i = '0;
    func_evt_i = '0;
    repeat (20) @(negedge clk_i);
    check_eq("R3 phase zero held while regulator not good", int'(phase_o), 0);
    push(1, -1, "R3 leave zero once regulator good");
    push(2, 351, "R5 phase one dwell");
    flash_done_i = 1'b0;
    vreg_ok_i = 1'b1;
    wait_phase(2);
    repeat (30) @(negedge clk_i);
    check_eq("R6 phase two held without flash done", int'(phase_o), 2);
    push(3, -1, "R6 leave two once flash done");
    push(4, 41, "R8 phase three dwell");
    flash_done_i = 1'b1;
    wait_phase(4);

    // destructive from idle; long functional in phase zero ignored
    push(0, -1, "R2 destructive from idle");
    push(1, 4,  "R3/R4 zero dwell, functional ignored in zero");
    push(2, 351, "R5 phase one dwell");
    push(3, 9,  "R6 phase two dwell");
    push(4, 41, "R8 phase three dwell");
    pulse_dstr(0);
    pulse_func(0);
    wait_phase(4);

    repeat (5) @(negedge clk_i);
    check_eq("R9 hold released in idle", int'(sys_rst_hold_o), 0);
    check_eq("scoreboard drained", sb.size(), 0);
    finish_run();
  end

endmodule